// File: doc/BRIEF.md
# Strap-Selected Byte-Order Bridge

This block sits on the CPU side of a system controller, between a 32-bit CPU address/data bus and an internal fabric that only understands little-endian byte order. It takes the CPU's address, access size, write data and byte enables, and produces what the fabric sees. In the other direction it turns fabric read data into the lane image the CPU expects. All of the translation is combinational, so it adds no cycles to any access.

Two strap inputs pick the byte-order handling. The straps are captured only while reset is held. When the CPU runs little-endian, everything passes through unchanged. When it runs big-endian, one of two methods applies. Lane-reversal mode mirrors the data byte lanes and byte enables in both directions. Address-adjust mode leaves the lanes alone and rewrites the low address bits of sub-word accesses instead.

The choice is held by a three-state mode machine:

- `ST_LE`: pass-through.
- `ST_BE_DSWAP`: lane reversal.
- `ST_BE_ASWAP`: address adjust.

It has two transitions:

- **Strap capture**: on every clock edge while `rst_n` is low, the machine moves to the state decoded from the straps.
- **Hold**: once `rst_n` is high, it stays in its state.

Top module: `endian_xlate`

## Requirements
- R1: In little-endian mode, the outputs copy their inputs in the same cycle: `fab_addr` from `cpu_addr`, `fab_wdata` from `cpu_wdata`, `fab_wbe` from `cpu_wbe`, and `cpu_rdata` from `fab_rdata`.
- R2: On each clock edge with `rst_n` low, the mode is captured from the straps:
  - `strap_big`=0 selects little-endian, whatever `strap_addr_mode` is.
  - `strap_big`=1 with `strap_addr_mode`=0 selects lane reversal.
  - `strap_big`=1 with `strap_addr_mode`=1 selects address adjust.
- R3: While `rst_n` is high, changes on either strap have no effect on the translation.
- R4: In lane-reversal mode, write data byte lane k (bits 8k+7:8k) appears on fabric lane 3-k, and byte-enable bit k moves to bit 3-k. The address is unchanged.
- R5: In lane-reversal mode, fabric read lane k is returned on CPU lane 3-k.
- R6: In address-adjust mode, a byte access (`cpu_size`=00) has address bits 1:0 XORed with 3.
- R7: In address-adjust mode, a halfword access (`cpu_size`=01) has address bits 1:0 XORed with 2.
- R8: In address-adjust mode, a word access (`cpu_size`=10) and the reserved size 11 leave the address unchanged.
- R9: In address-adjust mode, the following pass unchanged:
  - write data, read data and byte enables;
  - address bits 31:2, for every size.
- R10: In every mode, a value written at an address with a given size reads back unchanged at the same address and size. A byte read returns the byte the CPU stored at that byte address under its own byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; straps are captured on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; straps are sampled while low |
| strap_big | input | 1 | High selects big-endian CPU byte order |
| strap_addr_mode | input | 1 | In big-endian: low selects lane reversal, high selects address adjust |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved (treated as word) |
| cpu_wdata | input | 32 | CPU write data lanes |
| cpu_wbe | input | 4 | CPU byte enables, one per lane |
| cpu_rdata | output | 32 | Read data returned to the CPU |
| fab_addr | output | 32 | Address presented to the fabric |
| fab_wdata | output | 32 | Write data presented to the fabric |
| fab_wbe | output | 4 | Byte enables presented to the fabric |
| fab_rdata | input | 32 | Read data from the fabric |

## Verification
Two things can land in the same cycle:

- **Strap toggle with an access.** A strap can move in the very cycle an access is on the bus. The bench flips both straps at the same negative edge where it presents a write in lane-reversal mode. The translation seen before the next edge, and in later accesses, must still follow the mode captured at reset.
- **Read return with a presented write.** The fabric read return and the CPU write image are present together, because the paths are purely combinational. The bench keeps a non-zero `fab_rdata` during writes and re-derives each read value from a CPU-view reference memory. A swapped-direction mix-up then shows as a wrong read-back.

// File: rtl/endian_xlate_pkg.sv
package endian_xlate_pkg;

    typedef enum logic [1:0] {
        ST_LE       = 2'd0,
        ST_BE_DSWAP = 2'd1,
        ST_BE_ASWAP = 2'd2
    } xmode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xsize_e;

    function automatic xmode_e decode_straps(input logic big, input logic addr_mode);
        if (!big)
            return ST_LE;
        else if (addr_mode)
            return ST_BE_ASWAP;
        else
            return ST_BE_DSWAP;
    endfunction

endpackage

// File: rtl/endian_xlate_mode_fsm.sv
module endian_xlate_mode_fsm
    import endian_xlate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   strap_big,
    input  logic   strap_addr_mode,
    output xmode_e mode
);

    xmode_e state_q;
    xmode_e state_d;

    // Next state: strap capture under reset, hold otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LE:       state_d = ST_LE;
            ST_BE_DSWAP: state_d = ST_BE_DSWAP;
            ST_BE_ASWAP: state_d = ST_BE_ASWAP;
            default:     state_d = ST_LE;
        endcase
        if (!rst_n)
            state_d = decode_straps(strap_big, strap_addr_mode);
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign mode = state_q;

    // R3: once out of reset the selected mode never moves
    a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(state_q));

    // R2: a captured mode is always one of the three legal states
    a_r2_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != xmode_e'(2'd3));

endmodule

// File: rtl/endian_xlate_lane_rev.sv
module endian_xlate_lane_rev #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0] data_in,
    input  logic [LANES-1:0]   mask_in,
    output logic [LANES*8-1:0] data_out,
    output logic [LANES-1:0]   mask_out
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign data_out[8*k +: 8] = data_in[8*(LANES-1-k) +: 8];
        assign mask_out[k]        = mask_in[LANES-1-k];
    end

endmodule

// File: rtl/endian_xlate_addr_adj.sv
module endian_xlate_addr_adj
    import endian_xlate_pkg::*;
#(
    parameter int LANES = 4,
    localparam int LSB = $clog2(LANES)
) (
    input  logic [LSB-1:0] lo_in,
    input  logic [1:0]     size,
    output logic [LSB-1:0] lo_out
);

    localparam logic [LSB-1:0] FLIP_BYTE = LSB'(LANES - 1);
    localparam logic [LSB-1:0] FLIP_HALF = LSB'(LANES - 2);

    always_comb begin
        unique case (xsize_e'(size))
            SZ_BYTE: lo_out = lo_in ^ FLIP_BYTE;
            SZ_HALF: lo_out = lo_in ^ FLIP_HALF;
            SZ_WORD: lo_out = lo_in;
            SZ_RSVD: lo_out = lo_in;
            default: lo_out = lo_in;
        endcase
    end

endmodule

// File: rtl/endian_xlate.sv
module endian_xlate
    import endian_xlate_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LSB   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_big,
    input  logic              strap_addr_mode,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [LANES-1:0]  cpu_wbe,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] fab_addr,
    output logic [DATA_W-1:0] fab_wdata,
    output logic [LANES-1:0]  fab_wbe,
    input  logic [DATA_W-1:0] fab_rdata
);

    xmode_e            mode;
    logic [DATA_W-1:0] wdata_rev;
    logic [LANES-1:0]  wbe_rev;
    logic [DATA_W-1:0] rdata_rev;
    logic [LANES-1:0]  rmask_unused;
    logic [LSB-1:0]    lo_adj;

    endian_xlate_mode_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .strap_big       (strap_big),
        .strap_addr_mode (strap_addr_mode),
        .mode            (mode)
    );

    endian_xlate_lane_rev #(.LANES(LANES)) u_wrev (
        .data_in  (cpu_wdata),
        .mask_in  (cpu_wbe),
        .data_out (wdata_rev),
        .mask_out (wbe_rev)
    );

    endian_xlate_lane_rev #(.LANES(LANES)) u_rrev (
        .data_in  (fab_rdata),
        .mask_in  ({LANES{1'b0}}),
        .data_out (rdata_rev),
        .mask_out (rmask_unused)
    );

    endian_xlate_addr_adj #(.LANES(LANES)) u_adj (
        .lo_in  (cpu_addr[LSB-1:0]),
        .size   (cpu_size),
        .lo_out (lo_adj)
    );

    // Output process: route per captured mode
    always_comb begin
        fab_addr  = cpu_addr;
        fab_wdata = cpu_wdata;
        fab_wbe   = cpu_wbe;
        cpu_rdata = fab_rdata;
        unique case (mode)
            ST_LE: begin
            end
            ST_BE_DSWAP: begin
                fab_wdata = wdata_rev;
                fab_wbe   = wbe_rev;
                cpu_rdata = rdata_rev;
            end
            ST_BE_ASWAP: begin
                fab_addr = {cpu_addr[ADDR_W-1:LSB], lo_adj};
            end
            default: begin
            end
        endcase
    end

    // R1: little-endian is a plain pass-through
    a_r1_le_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_LE) |-> (fab_addr == cpu_addr && fab_wdata == cpu_wdata &&
                             fab_wbe == cpu_wbe && cpu_rdata == fab_rdata));

    // R4: lane reversal keeps the enable count and the address
    a_r4_dswap_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_BE_DSWAP) |-> ($countones(fab_wbe) == $countones(cpu_wbe) &&
                                   fab_addr == cpu_addr));

    // R5: lane reversal applied twice restores the fabric data
    a_r5_dswap_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_BE_DSWAP && cpu_wdata == fab_rdata) |-> (cpu_rdata == fab_wdata));

    // R6: byte access flips both low address bits
    a_r6_aswap_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_BE_ASWAP && cpu_size == 2'd0) |->
            ((fab_addr[LSB-1:0] ^ cpu_addr[LSB-1:0]) == LSB'(LANES - 1)));

    // R7: halfword access flips the halfword select bit
    a_r7_aswap_half: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_BE_ASWAP && cpu_size == 2'd1) |->
            ((fab_addr[LSB-1:0] ^ cpu_addr[LSB-1:0]) == LSB'(LANES - 2)));

    // R8: word and reserved sizes keep the address
    a_r8_aswap_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_BE_ASWAP && cpu_size[1]) |-> (fab_addr == cpu_addr));

    // R9: address adjust never touches lanes or upper address bits
    a_r9_aswap_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_BE_ASWAP) |-> (fab_wdata == cpu_wdata && fab_wbe == cpu_wbe &&
                                   cpu_rdata == fab_rdata &&
                                   fab_addr[ADDR_W-1:LSB] == cpu_addr[ADDR_W-1:LSB]));

endmodule

// File: tb/endian_xlate_tb.sv
module endian_xlate_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_big = 1'b0;
    logic        strap_addr_mode = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_wbe = '0;
    logic [31:0] cpu_rdata;
    logic [31:0] fab_addr;
    logic [31:0] fab_wdata;
    logic [3:0]  fab_wbe;
    logic [31:0] fab_rdata = 32'hDEAD_BEEF;

    int checks = 0;
    int errors = 0;
    int mode_sel = 0;   // 0 LE, 1 lane reversal, 2 address adjust
    bit done = 0;

    logic [7:0] fab_mem [64];   // fabric view, little-endian
    logic [7:0] cpu_mem [64];   // CPU view, byte address semantics

    endian_xlate u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .strap_big       (strap_big),
        .strap_addr_mode (strap_addr_mode),
        .cpu_addr        (cpu_addr),
        .cpu_size        (cpu_size),
        .cpu_wdata       (cpu_wdata),
        .cpu_wbe         (cpu_wbe),
        .cpu_rdata       (cpu_rdata),
        .fab_addr        (fab_addr),
        .fab_wdata       (fab_wdata),
        .fab_wbe         (fab_wbe),
        .fab_rdata       (fab_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic big, input logic amode, input int sel);
        @(negedge clk);
        rst_n = 1'b0;
        strap_big = big;
        strap_addr_mode = amode;
        mode_sel = sel;
        for (int i = 0; i < 64; i++) begin
            fab_mem[i] = 8'h00;
            cpu_mem[i] = 8'h00;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One CPU access; the bench plays the fabric from fab_mem
    task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] val, input string tag,
                          input bool_flip_straps = 0);
        int n;
        bit big;
        logic [31:0] cw, ew, ea, rd, ex;
        logic [3:0]  cbe, ebe;
        n   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        big = (mode_sel != 0);
        cw = '0; ew = '0; cbe = '0; ebe = '0; ex = '0;
        for (int i = 0; i < n; i++) begin
            int ai, lc, lf;
            logic [7:0] b;
            ai = int'(a) + i;
            lc = big ? 3 - (ai % 4) : (ai % 4);
            lf = (mode_sel == 2) ? lc : (ai % 4);
            b  = big ? val[8*(n-1-i) +: 8] : val[8*i +: 8];
            cw[8*lc +: 8] = b;
            cbe[lc] = 1'b1;
            ew[8*lf +: 8] = b;
            ebe[lf] = 1'b1;
            if (big) ex[8*(n-1-i) +: 8] = cpu_mem[ai % 64];
            else     ex[8*i +: 8]       = cpu_mem[ai % 64];
        end
        if (mode_sel == 2)
            ea = a ^ ((sz == 2'd0) ? 32'd3 : (sz == 2'd1) ? 32'd2 : 32'd0);
        else
            ea = a;

        @(negedge clk);
        cpu_addr  = a;
        cpu_size  = sz;
        cpu_wdata = wr ? cw : 32'h0;
        cpu_wbe   = cbe;
        if (bool_flip_straps) begin
            strap_big = ~strap_big;
            strap_addr_mode = ~strap_addr_mode;
        end
        #1;
        check(fab_addr == ea, {tag, " addr"}, fab_addr, ea);
        check(fab_wbe == {28'h0, ebe} [3:0], {tag, " wbe"}, {28'h0, fab_wbe}, {28'h0, ebe});
        if (wr) begin
            check(fab_wdata == ew, {tag, " wdata"}, fab_wdata, ew);
            for (int l = 0; l < 4; l++)
                if (ebe[l]) fab_mem[(int'(ea & ~32'd3) + l) % 64] = ew[8*l +: 8];
            for (int i = 0; i < n; i++) begin
                int ai;
                ai = int'(a) + i;
                cpu_mem[ai % 64] = big ? val[8*(n-1-i) +: 8] : val[8*i +: 8];
            end
        end else begin
            int wb;
            wb = int'(fab_addr & ~32'd3) % 64;
            fab_rdata = {fab_mem[wb+3], fab_mem[wb+2], fab_mem[wb+1], fab_mem[wb]};
            #1;
            rd = '0;
            for (int i = 0; i < n; i++) begin
                int ai, lc;
                ai = int'(a) + i;
                lc = big ? 3 - (ai % 4) : (ai % 4);
                if (big) rd[8*(n-1-i) +: 8] = cpu_rdata[8*lc +: 8];
                else     rd[8*i +: 8]       = cpu_rdata[8*lc +: 8];
            end
            check(rd == ex, {tag, " rdata"}, rd, ex);
            fab_rdata = 32'hA5C3_0F96;
        end
    endtask

    task automatic run_suite(input string m);
        access(1, 32'h0000_0000, 2'd2, 32'h1122_3344, {m, " R10 word write"});
        access(0, 32'h0000_0000, 2'd2, 32'h0, {m, " R10 word read"});
        access(0, 32'h0000_0000, 2'd0, 32'h0, {m, " R6 byte read a0"});
        access(0, 32'h0000_0003, 2'd0, 32'h0, {m, " R6 byte read a3"});
        access(0, 32'h0000_0002, 2'd1, 32'h0, {m, " R7 half read a2"});
        access(1, 32'h0000_0004, 2'd1, 32'h0000_A1B2, {m, " R7 half write a4"});
        access(1, 32'h0000_0006, 2'd1, 32'h0000_C3D4, {m, " R7 half write a6"});
        access(0, 32'h0000_0004, 2'd2, 32'h0, {m, " R10 word read a4"});
        access(1, 32'h0000_0009, 2'd0, 32'h0000_00E5, {m, " R6 byte write a9"});
        access(1, 32'h0000_000A, 2'd0, 32'h0000_00F6, {m, " R6 byte write aA"});
        access(0, 32'h0000_0008, 2'd1, 32'h0, {m, " R10 half read a8"});
        access(0, 32'h0000_000A, 2'd0, 32'h0, {m, " R10 byte read aA"});
        access(1, 32'h1234_5670, 2'd3, 32'hCAFE_F00D, {m, " R8 reserved-size write"});
        access(0, 32'h1234_5670, 2'd2, 32'h0, {m, " R9 upper bits read"});
    endtask

    initial begin
        // Reset state: LE straps (address-mode strap high is ignored, R2)
        @(negedge clk);
        strap_addr_mode = 1'b1;
        cpu_addr = 32'h0000_0001;
        cpu_size = 2'd0;
        cpu_wdata = 32'h0102_0304;
        cpu_wbe = 4'b0010;
        repeat (2) @(posedge clk);
        #1;
        check(fab_addr == 32'h1 && fab_wdata == 32'h0102_0304,
              "R2 reset state LE pass", fab_wdata, 32'h0102_0304);

        do_reset(1'b0, 1'b1, 0);
        run_suite("LE R1");

        do_reset(1'b1, 1'b0, 1);
        run_suite("DSWAP R4 R5");
        // R3: straps flip in the same cycle as a write, then stay flipped
        access(1, 32'h0000_0010, 2'd2, 32'h5566_7788, "DSWAP R3 strap flip write", 1);
        access(0, 32'h0000_0010, 2'd0, 32'h0, "DSWAP R3 after flip read");
        access(0, 32'h0000_0012, 2'd1, 32'h0, "DSWAP R3 after flip half");

        do_reset(1'b1, 1'b1, 2);
        run_suite("ASWAP R9");
        access(1, 32'h0000_0020, 2'd0, 32'h0000_0077, "ASWAP R3 strap flip write", 1);
        access(0, 32'h0000_0020, 2'd0, 32'h0, "ASWAP R3 after flip read");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule